// File: doc/BRIEF.md
# Two-Times Half-Band Interpolator

This block doubles the sample rate of a single real stream of 10-bit two's-complement samples. A new input sample may arrive at most once every two clocks. Each accepted sample produces two output samples on the next two clock edges. The first output is a delayed pass-through sample, because the centre tap of the half-band filter is the only non-zero coefficient at even distance. The second output is the interpolated midpoint. It is computed from symmetric pairs of stored samples weighted by a fixed integer coefficient set.

The filter is a 43-tap linear-phase half-band FIR. It is built as two polyphase branches. The pass-through branch is a plain tap of a 22-entry sample delay line. The interpolating branch adds the members of each symmetric pair first, then multiplies each pair sum by one of 11 odd-distance coefficients and sums the products at full precision. The result is rounded and clamped back to 10 bits. When inputs arrive every second clock, the output runs at one sample per clock with no gaps.

Top module: `hbi_interp2`

## Requirements
- R1: While `rst` is high and on the first edge after it rises, `out_valid` is 0 and `out_data` is 0. The delay line is cleared, so outputs after reset are computed as if every earlier sample were 0.
- R2: An input accepted on edge E produces exactly two outputs. The pass-through output is registered on edge E+1 and the interpolated output on edge E+2. `out_valid` is high on exactly those edges' cycles and low otherwise.
- R3: The pass-through output that follows the acceptance of sample n equals sample n-11 exactly. This is a gain of 4096/4096 at the centre tap.
- R4: The interpolated output that follows sample n is the sum over k = 1..11 of h_k * (x[n-11+k] + x[n-10-k]), divided by 4096. Here h_1..h_11 = 2590, -840, 470, -305, 208, -142, 96, -62, 38, -22, 17, and h_k sits at distance 2k-1 from the centre of the 43-tap response.
- R5: The division by 4096 rounds to nearest, with ties going toward positive infinity: add 2048, then shift right arithmetically by 12.
- R6: Rounded results above 511 are output as 511, and results below -512 are output as -512.
- R7: A sample accepted on edge E appears as a pass-through output registered on edge E+23, provided inputs keep arriving every second clock.
- R8: With inputs arriving every second clock, `out_valid` stays high on every cycle from the first output of the burst to the last, with two outputs per input.
- R9: Inputs may be spaced further apart than two clocks. Each input still yields its two outputs, and `in_valid` is never high on two consecutive edges.
- R10: The response to a single non-zero sample is symmetric around its pass-through output. The outputs m positions before and after that output are equal, for m = 1..21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe, at most every second clock |
| in_data | input | 10 | Input sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 10 | Output sample, two's complement |

## Verification
The bench builds the block with its default parameters: 10-bit data, 11 coefficient pairs, 13-bit coefficients and 12 fraction bits. With these values full-scale sign-alternating patterns push the interpolated sum well past both rails, so clamping is reached in both directions. The bench model restates the filter as a 43-tap convolution over a zero-stuffed input, independently of the polyphase split. A single impulse exposes the 23-edge latency and the mirror symmetry of the response. Random streams, both back-to-back and with gaps, exercise rounding on negative and positive sums.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Odd-distance coefficient k (distance 2k-1 from the centre), scale 2^12.
  function automatic int hb_coef(int k);
    case (k)
      1:  return 2590;
      2:  return -840;
      3:  return 470;
      4:  return -305;
      5:  return 208;
      6:  return -142;
      7:  return 96;
      8:  return -62;
      9:  return 38;
      10: return -22;
      11: return 17;
      default: return 0;
    endcase
  endfunction

  // Round half toward +inf, drop frac bits, clamp to a dw-bit signed range.
  function automatic int round_sat(longint acc, int frac, int dw);
    longint r;
    longint hi;
    longint lo;
    r  = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (dw - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) r = hi;
    else if (r < lo) r = lo;
    return int'(r);
  endfunction

endpackage

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 22
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          shift_en,
  input  logic [DATA_W-1:0]             din,
  output logic [DEPTH-1:0][DATA_W-1:0]  taps
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (shift_en) begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

endmodule

// File: rtl/hbi_odd_mac.sv
module hbi_odd_mac
  import hbi_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NPAIR  = 11,
  parameter int COEF_W = 13,
  parameter int ACC_W  = 29
) (
  input  logic [2*NPAIR-1:0][DATA_W-1:0] taps,
  output logic signed [ACC_W-1:0]        acc
);

  logic signed [ACC_W-1:0] part [NPAIR+1];
  assign part[0] = '0;

  for (genvar k = 1; k <= NPAIR; k++) begin : g_pair
    localparam logic signed [COEF_W-1:0] CK_N = COEF_W'(hb_coef(k));
    localparam logic signed [ACC_W-1:0]  CK   = ACC_W'(CK_N);
    logic [DATA_W-1:0]       near_s;
    logic [DATA_W-1:0]       far_s;
    logic signed [DATA_W:0]  pair;
    logic signed [ACC_W-1:0] pair_x;
    assign near_s = taps[NPAIR-k];
    assign far_s  = taps[NPAIR-1+k];
    assign pair   = $signed({near_s[DATA_W-1], near_s}) + $signed({far_s[DATA_W-1], far_s});
    assign pair_x = $signed({{(ACC_W-DATA_W-1){pair[DATA_W]}}, pair});
    assign part[k] = part[k-1] + pair_x * CK;
  end

  assign acc = part[NPAIR];

endmodule

// File: rtl/hbi_phase_ctl.sv
module hbi_phase_ctl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic emit_centre,
  output logic emit_half
);

  typedef enum logic [1:0] {PH_IDLE, PH_CTR, PH_HALF} phase_e;
  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (rst)                 ph_q <= PH_IDLE;
    else if (accept)         ph_q <= PH_CTR;
    else if (ph_q == PH_CTR) ph_q <= PH_HALF;
    else                     ph_q <= PH_IDLE;
  end

  assign emit_centre = (ph_q == PH_CTR);
  assign emit_half   = (ph_q == PH_HALF);

endmodule

// File: rtl/hbi_interp2.sv
module hbi_interp2
  import hbi_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NPAIR  = 11,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  localparam int DEPTH = 2 * NPAIR;
  localparam int ACC_W = DATA_W + 1 + COEF_W + $clog2(NPAIR) + 1;

  logic [DEPTH-1:0][DATA_W-1:0] taps;
  logic signed [ACC_W-1:0]      odd_acc;
  logic                         emit_centre;
  logic                         emit_half;
  logic [DATA_W-1:0]            centre_sample;
  logic [DATA_W-1:0]            half_sample;

  hbi_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dl (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_data), .taps(taps)
  );

  hbi_odd_mac #(.DATA_W(DATA_W), .NPAIR(NPAIR), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .taps(taps), .acc(odd_acc)
  );

  hbi_phase_ctl u_ph (
    .clk(clk), .rst(rst), .accept(in_valid),
    .emit_centre(emit_centre), .emit_half(emit_half)
  );

  // Centre coefficient equals 2^FRAC_W: the even phase is an exact copy.
  assign centre_sample = taps[NPAIR];
  assign half_sample   = DATA_W'(round_sat(longint'(odd_acc), FRAC_W, DATA_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit_centre | emit_half;
      if (emit_centre)    out_data <= centre_sample;
      else if (emit_half) out_data <= half_sample;
    end
  end

endmodule

// File: rtl/hbi_interp2_chk.sv
module hbi_interp2_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              emit_centre,
  input logic              emit_half,
  input logic [DATA_W-1:0] centre_sample
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  // R9
  in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> !in_valid);

  // R2
  centre_next_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (emit_centre && !emit_half));

  // R2
  half_next_chk: assert property (@(posedge clk) disable iff (rst)
    (emit_centre && !in_valid) |=> emit_half);

  // R2
  two_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);

  // R3
  centre_value_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 (out_valid && out_data == $past(centre_sample)));

endmodule

bind hbi_interp2 hbi_interp2_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .emit_centre(emit_centre), .emit_half(emit_half),
  .centre_sample(centre_sample)
);

// File: tb/hbi_interp2_test.sv
module hbi_interp2_test;

  localparam int DW = 10;
  localparam int NP = 11;
  localparam int FR = 12;
  localparam int NT = 4 * NP - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  wire           out_valid;
  wire  [DW-1:0] out_data;

  always #4 clk = ~clk;

  hbi_interp2 uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int    n_chk = 0;
  int    n_err = 0;
  int    exp_q[$];
  string tag_q[$];
  int    hist[NT];
  int    ncyc = 0;
  int    last_tag = 0;
  int    since_rst = 0;
  bit    hit_hi = 0, hit_lo = 0;
  bit    cap_on = 0;
  int    cap[$];
  int    cap_cnt = 0, first_cyc = 0, last_cyc = 0, peak_cyc = -1;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Full 43-tap response g[t], centre at t = 21 (R4 table, centre 4096).
  function automatic int gcoef(int t);
    int off, k;
    off = t - (NT - 1) / 2;
    if (off == 0) return 4096;
    if (off % 2 == 0) return 0;
    k = ((off < 0 ? -off : off) + 1) / 2;
    case (k)
      1: return 2590;  2: return -840; 3: return 470;  4: return -305;
      5: return 208;   6: return -142; 7: return 96;   8: return -62;
      9: return 38;    10: return -22; 11: return 17;
      default: return 0;
    endcase
  endfunction

  // Convolution over the zero-stuffed stream, R5 rounding and R6 clamp.
  function automatic int conv();
    longint acc = 0;
    longint r;
    for (int t = 0; t < NT; t++) acc += longint'(gcoef(t)) * hist[t];
    r = (acc + 2048) >>> FR;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return int'(r);
  endfunction

  task automatic push_hist(int v);
    for (int t = NT - 1; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
  endtask

  task automatic send(int x, int gap);
    @(negedge clk);
    exp_q.push_back(conv());
    tag_q.push_back(since_rst < NP ? "R1" : "R3");
    push_hist(x);
    exp_q.push_back(conv());
    tag_q.push_back("R4");
    push_hist(0);
    since_rst++;
    in_data  = DW'(x);
    in_valid = 1'b1;
    #1 last_tag = ncyc;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    for (int t = 0; t < NT; t++) hist[t] = 0;
    since_rst = 0;
    repeat (2) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 data in reset", int'(out_data), 0);
    rst = 1'b0;
  endtask

  task automatic rand_x(output int x);
    x = int'($urandom_range(1023)) - 512;
  endtask

  // Sign pattern that drives the interpolated sum to a rail (R6).
  task automatic sat_burst(bit pos);
    for (int i = 0; i < 2 * NP; i++) begin
      int j, s;
      j = 2 * NP - 1 - i;
      if (j <= NP - 1) s = ((NP - 1 - j) % 2 == 0) ? 1 : -1;
      else             s = ((j - NP) % 2 == 0) ? 1 : -1;
      if (!pos) s = -s;
      send(s > 0 ? 511 : -512, 0);
    end
    send(0, 0);
  endtask

  always @(negedge clk) begin
    int v, e;
    string tg;
    ncyc++;
    if (!rst && out_valid) begin
      v = int'($signed(out_data));
      if (exp_q.size() == 0) begin
        n_chk++;
        n_err++;
        $display("FAIL R2: actual output %0d expected none", v);
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(tg, v, e);
      end
      if (v == 511)  hit_hi = 1;
      if (v == -512) hit_lo = 1;
      if (cap_on) begin
        cap.push_back(v);
        if (cap_cnt == 0) first_cyc = ncyc;
        last_cyc = ncyc;
        cap_cnt++;
        if (v == 300 && peak_cyc < 0) peak_cyc = ncyc;
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int imp_tag, x;
    for (int t = 0; t < NT; t++) hist[t] = 0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 data in reset", int'(out_data), 0);
    rst = 1'b0;

    // Impulse: latency R7, symmetry R10, gapless stream R8
    cap_on = 1;
    send(300, 0);
    imp_tag = last_tag;
    for (int i = 0; i < 30; i++) send(0, 0);
    repeat (4) @(negedge clk);
    cap_on = 0;
    // Edge E+23 is observed at the 24th falling edge after the drive edge.
    check("R7 latency", peak_cyc - imp_tag, 2 * NP + 2);
    check("R8 output count", cap_cnt, 62);
    check("R8 contiguous valid", last_cyc - first_cyc + 1, cap_cnt);
    check("R3 impulse peak", cap[2*NP], 300);
    check("R4 first pair", cap[2*NP-1], (300 * 2590 + 2048) >>> FR);
    for (int m = 1; m <= 2 * NP - 1; m++) check("R10 symmetry", cap[2*NP-m], cap[2*NP+m]);

    // Random back-to-back stream
    for (int i = 0; i < 200; i++) begin
      rand_x(x);
      send(x, 0);
    end
    // Random stream with irregular gaps (R9)
    for (int i = 0; i < 150; i++) begin
      rand_x(x);
      send(x, int'($urandom_range(3)));
    end
    repeat (4) @(negedge clk);

    // Saturation both ways (R6)
    hit_hi = 0;
    hit_lo = 0;
    sat_burst(1'b1);
    sat_burst(1'b0);
    repeat (4) @(negedge clk);
    check("R6 upper rail reached", int'(hit_hi), 1);
    check("R6 lower rail reached", int'(hit_lo), 1);

    // Reset in mid stream clears history (R1)
    for (int i = 0; i < 8; i++) send(400 - 90 * i, 0);
    repeat (4) @(negedge clk);
    do_reset();
    for (int i = 0; i < 15; i++) begin
      rand_x(x);
      send(x, 0);
    end
    repeat (6) @(negedge clk);
    check("R2 all outputs delivered", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule